// File: doc/BRIEF.md
# Interrupt Acceptance and Enable Flags

This block is the interrupt decision and enable-state logic of a small 8-bit CPU core. The core has one edge-triggered non-maskable request and one level-sensitive maskable request. The block keeps two enable bits: a live enable that gates the maskable request, and a saved copy that holds the live value while a non-maskable handler runs. At every instruction boundary the core reports, the block decides whether to divert the core. When it does, it raises a one-cycle take pulse. The pulse carries the handler address, a push request and the return address to push.

The core's decoder sends three single-cycle strobes: enable, disable and return-from-non-maskable. The block updates the two bits from these strobes and answers the return strobe with a pop request. Non-maskable acceptance clears only the live bit. It is accepted even inside a running non-maskable handler. As a result, a nested return copies the saved bit back to the live bit and re-opens maskable interrupts inside the outer handler. This behaviour is kept on purpose.

Top module: `irq_accept_flags`

## Requirements
- R1: After reset both enable bits read 0, and take, push and pop requests are all 0.
- R2: An enable strobe sets both enable bits to 1 in the next cycle. A disable strobe clears both bits to 0 in the next cycle.
- R3: A high-to-low transition on `nmi_n` is latched as pending one clock after it is sampled. A level held low latches only once, and the pending bit clears when the request is taken.
- R4: A pending non-maskable request is taken at a boundary. The take pulse shows `take_nmi_o`=1, `vector_o`=0x0066, a push request and `push_data_o` equal to `pc_i` at the boundary. The live bit is cleared and the saved bit is unchanged.
- R5: A return strobe copies the saved bit into the live bit and gives a one-cycle `pop_req_o` in the next cycle.
- R6: A non-maskable request is taken while the live bit is 0, including inside a non-maskable handler. After the inner return, the live bit is 1 when maskable interrupts were enabled before the outer request, and a maskable request can then be taken.
- R7: A maskable request is taken at a boundary when `irq_n` is 0 and the live bit is 1. The take pulse shows `take_nmi_o`=0, `vector_o`=0x0038, a push request and `push_data_o` equal to `pc_i`. Both enable bits are cleared.
- R8: A maskable request is not taken when the live bit is 0, and it is not taken away from a boundary.
- R9: When a non-maskable request is pending and `irq_n` is 0 at the same boundary, the non-maskable request is taken.
- R10: A boundary that arrives in the same cycle as any strobe takes nothing. The strobe is applied, and a pending request is taken at the next boundary.
- R11: Take and pop requests last exactly one cycle, and the push request rises and falls together with the take pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive, synchronous to clk |
| irq_n | input | 1 | Maskable request, active-low level |
| insn_end | input | 1 | High for one cycle at each instruction boundary |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| retn_stb | input | 1 | Return-from-non-maskable strobe |
| pc_i | input | ADDR_W | Address of the next instruction at the boundary |
| take_o | output | 1 | One-cycle pulse: the core must divert |
| take_nmi_o | output | 1 | With take_o: 1 for non-maskable, 0 for maskable |
| vector_o | output | ADDR_W | Handler address during take_o |
| push_req_o | output | 1 | Request to push the return address |
| push_data_o | output | ADDR_W | Return address to push |
| pop_req_o | output | 1 | Request to pop the return address |
| ie_main_o | output | 1 | Live enable bit that gates maskable requests |
| ie_saved_o | output | 1 | Saved copy of the enable bit |

## Verification
The checker assumes that the decoder raises at most one of the three strobes in a cycle. It also assumes that `nmi_n` is already synchronous to the clock, so one sampled low follows each falling edge. The stimulus drives every input on the falling clock edge. It pulses each strobe alone for one cycle, and it moves `nmi_n` only between whole cycles. It also steers the flag state through each nesting and coincidence case on purpose, so that no take pulse arrives that the scoreboard did not predict.

// File: rtl/iaf_pkg.sv
package iaf_pkg;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_NMI  = 2'd1,
        TAKE_INT  = 2'd2
    } take_e;

    typedef struct packed {
        logic live;
        logic saved;
    } ie_t;

endpackage

// File: rtl/iaf_nmi_latch.sv
module iaf_nmi_latch #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clear_i,
    output logic pending_o
);

    localparam int CHAIN = (SYNC_STAGES > 0) ? SYNC_STAGES : 1;

    logic line_w;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [CHAIN-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[CHAIN-2:0], nmi_n};
            end
            assign line_w = chain_q[CHAIN-1];
        end else begin : g_direct
            assign line_w = nmi_n;
        end
    endgenerate

    typedef struct packed {
        logic prev;
        logic pending;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d         = det_q;
        det_d.prev    = line_w;
        // a fresh edge wins over a clear in the same cycle
        det_d.pending = (det_q.prev & ~line_w) | (det_q.pending & ~clear_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '{prev: 1'b1, pending: 1'b0};
        else        det_q <= det_d;
    end

    assign pending_o = det_q.pending;

endmodule

// File: rtl/iaf_arbiter.sv
module iaf_arbiter
    import iaf_pkg::*;
(
    input  logic  insn_end,
    input  logic  any_strobe,
    input  logic  nmi_pending,
    input  logic  ie_live,
    input  logic  irq_n,
    output take_e kind_o
);

    logic boundary_w;

    always_comb begin
        boundary_w = insn_end & ~any_strobe;
        kind_o     = TAKE_NONE;
        if (boundary_w) begin
            if (nmi_pending)            kind_o = TAKE_NMI;
            else if (ie_live && !irq_n) kind_o = TAKE_INT;
        end
    end

endmodule

// File: rtl/iaf_flags.sv
module iaf_flags
    import iaf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ei_stb,
    input  logic  di_stb,
    input  logic  retn_stb,
    input  take_e kind_i,
    output logic  live_o,
    output logic  saved_o
);

    ie_t ie_d, ie_q;

    always_comb begin
        ie_d = ie_q;
        unique case (kind_i)
            TAKE_NMI: ie_d.live = 1'b0;
            TAKE_INT: ie_d      = '{live: 1'b0, saved: 1'b0};
            default: begin
                if (di_stb)        ie_d = '{live: 1'b0, saved: 1'b0};
                else if (ei_stb)   ie_d = '{live: 1'b1, saved: 1'b1};
                else if (retn_stb) ie_d.live = ie_q.saved;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= '0;
        else        ie_q <= ie_d;
    end

    assign live_o  = ie_q.live;
    assign saved_o = ie_q.saved;

endmodule

// File: rtl/irq_accept_flags.sv
module irq_accept_flags
    import iaf_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC   = 16'h0066,
    parameter logic [ADDR_W-1:0] INT_VEC   = 16'h0038,
    parameter int              SYNC_STAGES = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_n,
    input  logic              irq_n,
    input  logic              insn_end,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              retn_stb,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              take_o,
    output logic              take_nmi_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic              push_req_o,
    output logic [ADDR_W-1:0] push_data_o,
    output logic              pop_req_o,
    output logic              ie_main_o,
    output logic              ie_saved_o
);

    typedef struct packed {
        take_e             kind;
        logic [ADDR_W-1:0] vec;
        logic [ADDR_W-1:0] ret;
        logic              pop;
    } out_t;

    take_e kind_w;
    logic  pending_w;
    logic  any_strobe_w;
    logic  live_w;
    logic  saved_w;
    out_t  out_d, out_q;

    assign any_strobe_w = ei_stb | di_stb | retn_stb;

    iaf_nmi_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_n     (nmi_n),
        .clear_i   (kind_w == TAKE_NMI),
        .pending_o (pending_w)
    );

    iaf_arbiter u_arb (
        .insn_end    (insn_end),
        .any_strobe  (any_strobe_w),
        .nmi_pending (pending_w),
        .ie_live     (live_w),
        .irq_n       (irq_n),
        .kind_o      (kind_w)
    );

    iaf_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ei_stb   (ei_stb),
        .di_stb   (di_stb),
        .retn_stb (retn_stb),
        .kind_i   (kind_w),
        .live_o   (live_w),
        .saved_o  (saved_w)
    );

    always_comb begin
        out_d      = '0;
        out_d.kind = kind_w;
        out_d.pop  = retn_stb;
        unique case (kind_w)
            TAKE_NMI: begin
                out_d.vec = NMI_VEC;
                out_d.ret = pc_i;
            end
            TAKE_INT: begin
                out_d.vec = INT_VEC;
                out_d.ret = pc_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign take_o      = (out_q.kind != TAKE_NONE);
    assign take_nmi_o  = (out_q.kind == TAKE_NMI);
    assign vector_o    = out_q.vec;
    assign push_req_o  = (out_q.kind != TAKE_NONE);
    assign push_data_o = out_q.ret;
    assign pop_req_o   = out_q.pop;
    assign ie_main_o   = live_w;
    assign ie_saved_o  = saved_w;

endmodule

// File: rtl/iaf_checker.sv
module iaf_checker #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] INT_VEC = 16'h0038
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              insn_end,
    input logic              ei_stb,
    input logic              di_stb,
    input logic              retn_stb,
    input logic [ADDR_W-1:0] pc_i,
    input logic              take_o,
    input logic              take_nmi_o,
    input logic [ADDR_W-1:0] vector_o,
    input logic              push_req_o,
    input logic [ADDR_W-1:0] push_data_o,
    input logic              pop_req_o,
    input logic              ie_main_o,
    input logic              ie_saved_o
);

    // R2 (input rule: decoder strobes are mutually exclusive)
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ei_stb, di_stb, retn_stb}));

    // R2
    ei_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ei_stb |=> ie_main_o && ie_saved_o);

    // R2
    di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        di_stb |=> !ie_main_o && !ie_saved_o);

    // R4
    nmi_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_nmi_o) |-> (vector_o == NMI_VEC) && !ie_main_o && push_req_o);

    // R4
    nmi_keeps_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && take_nmi_o) |-> (ie_saved_o == $past(ie_saved_o)));

    // R5
    retn_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retn_stb |=> pop_req_o && (ie_main_o == ie_saved_o));

    // R7
    int_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_nmi_o) |-> (vector_o == INT_VEC) && !ie_main_o && !ie_saved_o);

    // R8
    int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !take_nmi_o) |-> $past(ie_main_o) && !$past(irq_n) && $past(insn_end));

    // R10
    strobe_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_stb || di_stb || retn_stb) |=> !take_o);

    // R11
    push_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> push_req_o && (push_data_o == $past(pc_i)));

endmodule

bind irq_accept_flags iaf_checker #(
    .ADDR_W  (ADDR_W),
    .NMI_VEC (NMI_VEC),
    .INT_VEC (INT_VEC)
) u_iaf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_n       (irq_n),
    .insn_end    (insn_end),
    .ei_stb      (ei_stb),
    .di_stb      (di_stb),
    .retn_stb    (retn_stb),
    .pc_i        (pc_i),
    .take_o      (take_o),
    .take_nmi_o  (take_nmi_o),
    .vector_o    (vector_o),
    .push_req_o  (push_req_o),
    .push_data_o (push_data_o),
    .pop_req_o   (pop_req_o),
    .ie_main_o   (ie_main_o),
    .ie_saved_o  (ie_saved_o)
);

// File: tb/tb_irq_accept_flags.sv
module tb_irq_accept_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n = 1'b1;
    logic        irq_n = 1'b1;
    logic        insn_end = 1'b0;
    logic        ei_stb = 1'b0;
    logic        di_stb = 1'b0;
    logic        retn_stb = 1'b0;
    logic [15:0] pc_i = '0;
    logic        take_o, take_nmi_o, push_req_o, pop_req_o, ie_main_o, ie_saved_o;
    logic [15:0] vector_o, push_data_o;

    always #5 clk = ~clk;

    irq_accept_flags dut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .insn_end(insn_end), .ei_stb(ei_stb), .di_stb(di_stb),
        .retn_stb(retn_stb), .pc_i(pc_i), .take_o(take_o),
        .take_nmi_o(take_nmi_o), .vector_o(vector_o),
        .push_req_o(push_req_o), .push_data_o(push_data_o),
        .pop_req_o(pop_req_o), .ie_main_o(ie_main_o), .ie_saved_o(ie_saved_o)
    );

    localparam int K_NMI = 1;
    localparam int K_INT = 2;
    localparam int K_POP = 3;

    typedef struct {
        string       req;
        int          kind;
        logic [15:0] vec;
        logic [15:0] data;
    } exp_t;

    exp_t sb[$];
    exp_t mon_e;
    int   n_cmp = 0;
    int   n_bad = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(string req, int kind, logic [15:0] vec, logic [15:0] data);
        exp_t e;
        e.req = req; e.kind = kind; e.vec = vec; e.data = data;
        sb.push_back(e);
    endtask

    // called at a falling edge; returns at the next falling edge with outputs of that cycle
    task automatic step(bit be, bit e, bit d, bit r);
        insn_end = be; ei_stb = e; di_stb = d; retn_stb = r;
        @(posedge clk);
        @(negedge clk);
        insn_end = 1'b0; ei_stb = 1'b0; di_stb = 1'b0; retn_stb = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (take_o) begin
                if (sb.size() == 0) begin
                    check("R11 unexpected take", {take_nmi_o, vector_o}, 32'h0);
                end else begin
                    mon_e = sb.pop_front();
                    check({mon_e.req, " kind"}, take_nmi_o ? K_NMI : K_INT, mon_e.kind);
                    check({mon_e.req, " vector"}, vector_o, mon_e.vec);
                    check({mon_e.req, " push"}, push_req_o, 1);
                    check({mon_e.req, " ret"}, push_data_o, mon_e.data);
                end
            end
            if (pop_req_o) begin
                if (sb.size() == 0) begin
                    check("R5 unexpected pop", 1, 0);
                end else begin
                    mon_e = sb.pop_front();
                    check({mon_e.req, " pop"}, K_POP, mon_e.kind);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ie_main", ie_main_o, 0);
        check("R1 ie_saved", ie_saved_o, 0);
        check("R1 take", take_o, 0);
        check("R1 pop", pop_req_o, 0);
        check("R1 push", push_req_o, 0);

        // R2 enable / disable
        step(0, 1, 0, 0);
        check("R2 ei main", ie_main_o, 1);
        check("R2 ei saved", ie_saved_o, 1);
        step(0, 0, 1, 0);
        check("R2 di main", ie_main_o, 0);
        check("R2 di saved", ie_saved_o, 0);
        step(0, 1, 0, 0);

        // R7 maskable take
        irq_n = 1'b0; pc_i = 16'h1234;
        expect_ev("R7 int", K_INT, 16'h0038, 16'h1234);
        step(1, 0, 0, 0);
        check("R7 take", take_o, 1);
        check("R7 main", ie_main_o, 0);
        check("R7 saved", ie_saved_o, 0);
        step(0, 0, 0, 0);
        check("R11 take one cycle", take_o, 0);

        // R8 gating
        step(1, 0, 0, 0);
        check("R8 disabled", take_o, 0);
        irq_n = 1'b1;
        step(0, 1, 0, 0);
        irq_n = 1'b0;
        step(0, 0, 0, 0);
        check("R8 no boundary", take_o, 0);
        irq_n = 1'b1;

        // R4 non-maskable take with interrupts enabled
        nmi_n = 1'b0;
        step(0, 0, 0, 0);
        nmi_n = 1'b1;
        pc_i = 16'h2000;
        expect_ev("R4 nmi", K_NMI, 16'h0066, 16'h2000);
        step(1, 0, 0, 0);
        check("R4 take", take_o, 1);
        check("R4 main", ie_main_o, 0);
        check("R4 saved", ie_saved_o, 1);

        // R6 nested
        nmi_n = 1'b0;
        step(0, 0, 0, 0);
        nmi_n = 1'b1;
        pc_i = 16'h0070;
        expect_ev("R6 nested nmi", K_NMI, 16'h0066, 16'h0070);
        step(1, 0, 0, 0);
        check("R6 nested take", take_o, 1);
        check("R6 nested main", ie_main_o, 0);
        expect_ev("R5 pop", K_POP, 0, 0);
        step(0, 0, 0, 1);
        check("R5 pop", pop_req_o, 1);
        check("R6 main reopened", ie_main_o, 1);
        step(0, 0, 0, 0);
        check("R5 pop one cycle", pop_req_o, 0);
        irq_n = 1'b0; pc_i = 16'h0080;
        expect_ev("R6 int in outer", K_INT, 16'h0038, 16'h0080);
        step(1, 0, 0, 0);
        check("R6 int in outer", take_o, 1);
        irq_n = 1'b1;
        step(0, 1, 0, 0);

        // R3 level held low takes once
        nmi_n = 1'b0;
        step(0, 0, 0, 0);
        pc_i = 16'h3000;
        expect_ev("R3 nmi once", K_NMI, 16'h0066, 16'h3000);
        step(1, 0, 0, 0);
        check("R3 first", take_o, 1);
        step(1, 0, 0, 0);
        check("R3 held", take_o, 0);
        step(1, 0, 0, 0);
        check("R3 held again", take_o, 0);
        nmi_n = 1'b1;
        step(0, 0, 0, 0);
        expect_ev("R5 pop", K_POP, 0, 0);
        step(0, 0, 0, 1);
        check("R5 restore", ie_main_o, 1);

        // R9 priority
        nmi_n = 1'b0; irq_n = 1'b0;
        step(0, 0, 0, 0);
        nmi_n = 1'b1; pc_i = 16'h4000;
        expect_ev("R9 nmi wins", K_NMI, 16'h0066, 16'h4000);
        step(1, 0, 0, 0);
        check("R9 kind", take_nmi_o, 1);
        step(1, 0, 0, 0);
        check("R9 int blocked", take_o, 0);
        irq_n = 1'b1;
        expect_ev("R5 pop", K_POP, 0, 0);
        step(0, 0, 0, 1);

        // R10 return coincides with pending request
        nmi_n = 1'b0;
        step(0, 0, 0, 0);
        nmi_n = 1'b1; pc_i = 16'h5000;
        expect_ev("R10 pop first", K_POP, 0, 0);
        step(1, 0, 0, 1);
        check("R10 no take", take_o, 0);
        check("R10 main", ie_main_o, 1);
        expect_ev("R10 deferred nmi", K_NMI, 16'h0066, 16'h5000);
        step(1, 0, 0, 0);
        check("R10 deferred take", take_o, 1);
        expect_ev("R5 pop", K_POP, 0, 0);
        step(0, 0, 0, 1);

        // R10 enable strobe at a boundary
        step(0, 0, 1, 0);
        irq_n = 1'b0; pc_i = 16'h6000;
        step(1, 1, 0, 0);
        check("R10 ei boundary", take_o, 0);
        check("R10 ei applied", ie_main_o, 1);
        expect_ev("R10 int next", K_INT, 16'h0038, 16'h6000);
        step(1, 0, 0, 0);
        check("R10 int next", take_o, 1);
        irq_n = 1'b1;
        step(0, 0, 0, 0);
        check("R11 single", take_o, 0);

        repeat (3) step(0, 0, 0, 0);
        check("R11 scoreboard drained", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule